// File: doc/BRIEF.md
# TDM PCM Time-Slot Serial Port

This block connects four parallel 8-bit sample channels to a time-division-multiplexed PCM serial bus. The bus has a bit clock, a frame sync, a transmit data line with an output enable, a receive data line and an active-low slot indicator. All bus inputs are sampled by the block's own system clock, which must run several times faster than the bit clock. The block finds slot zero from the frame sync in one of two alignments. It then counts 8-bit slots. When a slot matches the slot number of a powered-up channel, the block shifts that channel's byte out most significant bit first. It also collects a byte for the receive channel that owns the slot.

Transmit samples enter through a per-channel valid/ready pair. `tx_ready_o[c]` pulses for one cycle when channel c's slot begins, and the byte on `tx_data_i` is taken in that cycle. The core cannot hold the bus back. If `tx_valid_i[c]` is low at that moment, the slot carries the idle byte. Received bytes leave as a one-cycle `rx_valid_o` strobe with the byte and its channel number. There is no ready on this side: the consumer must accept the strobe in the cycle it appears.

A small write-only control port sets the slot numbers, the per-channel power-up codes and the frame alignment.

Top module: `pcm_tdm_port`

## Requirements
- R1: After reset, every channel is powered down, every slot number is 0, the alignment is delay mode, `txd_oe_o` is 0, `slot_ind_n_o` is 1, and `rx_valid_o` and `tx_ready_o` are 0.
- R2: Transmit bits change only after a rising bit-clock edge. Each slot carries 8 bits, most significant bit first, and `txd_o` holds the current bit for the whole bit period.
- R3: Receive bits are sampled at falling bit-clock edges, most significant bit first. After the 8th falling edge of a receive slot, `rx_valid_o` is high for exactly one system clock, with the byte on `rx_data_o` and the owning channel on `rx_ch_o`. There is no back-pressure.
- R4: In delay mode (mode bit 1), bit 0 of slot 0 starts at the first rising edge after a falling edge that sees frame sync high, where the previous falling edge saw it low.
- R5: In non-delay mode (mode bit 0), bit 0 of slot 0 starts at a rising edge that sees frame sync high, where the previous rising edge saw it low.
- R6: The 2-bit power-up code of a channel works as follows: bit 1 enables transmit and bit 0 enables receive. So 00 is off, 01 is receive only, 10 is transmit only and 11 is both. A disabled direction drives no bits and produces no strobes.
- R7: `txd_oe_o` is 1 and `slot_ind_n_o` is 0 during all 8 bits of a slot owned by a transmit-enabled channel. At all other times `txd_oe_o` is 0 and `slot_ind_n_o` is 1.
- R8: When several enabled channels share a slot number in the same direction, the lowest-numbered channel owns that slot.
- R9: `tx_ready_o` has at most one bit set. It pulses once at the start of each owned transmit slot. The byte is taken when the valid bit is high; otherwise the idle byte 8'hFF is sent.
- R10: After 1024 bits (128 slots), counting stops, and no slot is active until the next frame start. A new frame start restarts counting at any point.
- R11: A write (`ctl_we_i` = 1) with `ctl_sel_i` = 00 sets the transmit slot of channel `ctl_ch_i` from `ctl_data_i[6:0]`. Select 01 sets the receive slot. Select 10 sets the power-up code from `ctl_data_i[1:0]`. Select 11 sets the mode from `ctl_data_i[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_sel_i | input | 2 | Control target select |
| ctl_ch_i | input | 2 | Channel for the write |
| ctl_data_i | input | 7 | Write data |
| bclk_i | input | 1 | PCM bit clock |
| fsync_i | input | 1 | PCM frame sync |
| rxd_i | input | 1 | PCM receive data |
| txd_o | output | 1 | PCM transmit data |
| txd_oe_o | output | 1 | Transmit line enable |
| slot_ind_n_o | output | 1 | Active-low transmit slot indicator (open-drain at the pad) |
| tx_data_i | input | 32 | Transmit bytes, channel c at bits 8c+7..8c |
| tx_valid_i | input | 4 | Transmit byte valid per channel |
| tx_ready_o | output | 4 | Transmit byte taken, per channel |
| rx_data_o | output | 8 | Received byte |
| rx_ch_o | output | 2 | Channel of the received byte |
| rx_valid_o | output | 1 | Received byte strobe |

## Verification
The assertions check on every cycle that the transmit data and enable move only after a detected rising bit-clock edge. They also check that a receive strobe follows a detected falling edge and lasts one cycle, and that at most one ready bit is set. Frame alignment in both modes, slot ownership under collisions, the effect of power-up codes, the idle byte and the stop after 128 slots can only be shown by the bench scenarios. In those scenarios a bus model predicts each bit and each received byte.

// File: rtl/pcm_tdm_pkg.sv
package pcm_tdm_pkg;
  // Control port targets
  typedef enum logic [1:0] {
    CTL_TX_SLOT = 2'b00,
    CTL_RX_SLOT = 2'b01,
    CTL_POWER   = 2'b10,
    CTL_MODE    = 2'b11
  } ctl_sel_e;
endpackage

// File: rtl/pcm_ctl_regs.sv
module pcm_ctl_regs
  import pcm_tdm_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int SLOT_W = 7,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we_i,
  input  logic [1:0]                   sel_i,
  input  logic [CH_W-1:0]              ch_i,
  input  logic [SLOT_W-1:0]            data_i,
  output logic [NCH-1:0][SLOT_W-1:0]   tx_slots_o,
  output logic [NCH-1:0][SLOT_W-1:0]   rx_slots_o,
  output logic [NCH-1:0]               tx_en_o,
  output logic [NCH-1:0]               rx_en_o,
  output logic                         delay_mode_o
);
  ctl_sel_e sel;
  assign sel = ctl_sel_e'(sel_i);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit;
    assign hit = we_i && (ch_i == CH_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tx_slots_o[g] <= '0;
        rx_slots_o[g] <= '0;
        tx_en_o[g]    <= 1'b0;
        rx_en_o[g]    <= 1'b0;
      end else if (hit) begin
        case (sel)
          CTL_TX_SLOT: tx_slots_o[g] <= data_i;
          CTL_RX_SLOT: rx_slots_o[g] <= data_i;
          CTL_POWER: begin
            tx_en_o[g] <= data_i[1];
            rx_en_o[g] <= data_i[0];
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) delay_mode_o <= 1'b1;
    else if (we_i && sel == CTL_MODE) delay_mode_o <= data_i[0];
  end
endmodule

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_i,
  input  logic             fsync_i,
  input  logic             rxd_i,
  input  logic             delay_mode_i,
  output logic             rise_o,
  output logic             fall_o,
  output logic             rxd_o,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             nxt_run_o,
  output logic [CNT_W-1:0] nxt_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic bclk_s, bclk_d, fs_s;
  logic fs_at_rise, fs_at_fall, armed, start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_s <= 1'b0;
      bclk_d <= 1'b0;
      fs_s   <= 1'b0;
      rxd_o  <= 1'b0;
    end else begin
      bclk_s <= bclk_i;
      bclk_d <= bclk_s;
      fs_s   <= fsync_i;
      rxd_o  <= rxd_i;
    end
  end

  assign rise_o = bclk_s & ~bclk_d;
  assign fall_o = ~bclk_s & bclk_d;
  assign start  = rise_o & (delay_mode_i ? armed : (fs_s & ~fs_at_rise));

  always_comb begin
    nxt_cnt_o = cnt_o;
    nxt_run_o = run_o;
    if (start) begin
      nxt_cnt_o = '0;
      nxt_run_o = 1'b1;
    end else if (run_o) begin
      if (cnt_o == CNT_MAX) nxt_run_o = 1'b0;
      else                  nxt_cnt_o = cnt_o + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o      <= '0;
      run_o      <= 1'b0;
      fs_at_rise <= 1'b0;
      fs_at_fall <= 1'b0;
      armed      <= 1'b0;
    end else if (rise_o) begin
      cnt_o      <= nxt_cnt_o;
      run_o      <= nxt_run_o;
      fs_at_rise <= fs_s;
      armed      <= 1'b0;
    end else if (fall_o) begin
      fs_at_fall <= fs_s;
      if (fs_s && !fs_at_fall) armed <= 1'b1;
    end
  end

  // R10: a stopped counter stays stopped until a frame start
  a_r10_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_o && !start) |=> !run_o);
endmodule

// File: rtl/pcm_slot_match.sv
module pcm_slot_match #(
  parameter int NCH    = 4,
  parameter int SLOT_W = 7,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [SLOT_W-1:0]          slot_i,
  input  logic [NCH-1:0][SLOT_W-1:0] slots_i,
  input  logic [NCH-1:0]             en_i,
  output logic                       hit_o,
  output logic [CH_W-1:0]            idx_o
);
  logic [NCH-1:0] match;

  for (genvar g = 0; g < NCH; g++) begin : g_cmp
    assign match[g] = en_i[g] && (slots_i[g] == slot_i);
  end

  // Descending scan: the lowest matching channel is written last
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o = 1'b1;
        idx_o = CH_W'(i);
      end
    end
  end
endmodule

// File: rtl/pcm_tdm_port.sv
module pcm_tdm_port #(
  parameter int          NCH       = 4,
  parameter int          SLOT_W    = 7,
  parameter int          BYTE_W    = 8,
  parameter logic [7:0]  IDLE_BYTE = 8'hFF,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int BIT_W = $clog2(BYTE_W),
  localparam int CNT_W = SLOT_W + BIT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ctl_we_i,
  input  logic [1:0]              ctl_sel_i,
  input  logic [CH_W-1:0]         ctl_ch_i,
  input  logic [SLOT_W-1:0]       ctl_data_i,
  input  logic                    bclk_i,
  input  logic                    fsync_i,
  input  logic                    rxd_i,
  output logic                    txd_o,
  output logic                    txd_oe_o,
  output logic                    slot_ind_n_o,
  input  logic [NCH*BYTE_W-1:0]   tx_data_i,
  input  logic [NCH-1:0]          tx_valid_i,
  output logic [NCH-1:0]          tx_ready_o,
  output logic [BYTE_W-1:0]       rx_data_o,
  output logic [CH_W-1:0]         rx_ch_o,
  output logic                    rx_valid_o
);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

  logic [NCH-1:0][SLOT_W-1:0] tx_slots, rx_slots;
  logic [NCH-1:0]             tx_en, rx_en;
  logic                       delay_mode;

  pcm_ctl_regs #(.NCH(NCH), .SLOT_W(SLOT_W)) u_regs (
    .clk, .rst_n,
    .we_i(ctl_we_i), .sel_i(ctl_sel_i), .ch_i(ctl_ch_i), .data_i(ctl_data_i),
    .tx_slots_o(tx_slots), .rx_slots_o(rx_slots),
    .tx_en_o(tx_en), .rx_en_o(rx_en), .delay_mode_o(delay_mode)
  );

  logic             rise_evt, fall_evt, rxd_s, run, nxt_run;
  logic [CNT_W-1:0] cnt, nxt_cnt;

  pcm_frame_timer #(.CNT_W(CNT_W)) u_timer (
    .clk, .rst_n,
    .bclk_i, .fsync_i, .rxd_i, .delay_mode_i(delay_mode),
    .rise_o(rise_evt), .fall_o(fall_evt), .rxd_o(rxd_s),
    .run_o(run), .cnt_o(cnt), .nxt_run_o(nxt_run), .nxt_cnt_o(nxt_cnt)
  );

  logic [SLOT_W-1:0] nxt_slot;
  logic              slot_edge;
  assign nxt_slot  = nxt_cnt[CNT_W-1:BIT_W];
  assign slot_edge = rise_evt && nxt_run && (nxt_cnt[BIT_W-1:0] == '0);

  logic            tx_hit, rx_hit;
  logic [CH_W-1:0] tx_idx, rx_idx;

  pcm_slot_match #(.NCH(NCH), .SLOT_W(SLOT_W)) u_tx_match (
    .slot_i(nxt_slot), .slots_i(tx_slots), .en_i(tx_en),
    .hit_o(tx_hit), .idx_o(tx_idx)
  );

  pcm_slot_match #(.NCH(NCH), .SLOT_W(SLOT_W)) u_rx_match (
    .slot_i(nxt_slot), .slots_i(rx_slots), .en_i(rx_en),
    .hit_o(rx_hit), .idx_o(rx_idx)
  );

  // Transmit path
  logic              tx_load, tx_act;
  logic [BYTE_W-1:0] tx_byte, tx_sh;

  assign tx_load = slot_edge && tx_hit;
  assign tx_byte = tx_valid_i[tx_idx] ? tx_data_i[tx_idx*BYTE_W +: BYTE_W] : BYTE_W'(IDLE_BYTE);

  for (genvar g = 0; g < NCH; g++) begin : g_rdy
    assign tx_ready_o[g] = tx_load && (tx_idx == CH_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_act <= 1'b0;
      tx_sh  <= '0;
    end else if (rise_evt) begin
      if (!nxt_run) begin
        tx_act <= 1'b0;
      end else if (nxt_cnt[BIT_W-1:0] == '0) begin
        tx_act <= tx_hit;
        if (tx_hit) tx_sh <= tx_byte;
      end else begin
        tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign txd_o        = tx_sh[BYTE_W-1] & tx_act;
  assign txd_oe_o     = tx_act;
  assign slot_ind_n_o = ~tx_act;

  // Receive path
  logic              rx_act;
  logic [CH_W-1:0]   rx_cur;
  logic [BYTE_W-1:0] rx_sh, rx_next;
  assign rx_next = {rx_sh[BYTE_W-2:0], rxd_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_act     <= 1'b0;
      rx_cur     <= '0;
      rx_sh      <= '0;
      rx_data_o  <= '0;
      rx_ch_o    <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (rise_evt) begin
        if (!nxt_run) begin
          rx_act <= 1'b0;
        end else if (slot_edge) begin
          rx_act <= rx_hit;
          rx_cur <= rx_idx;
        end
      end else if (fall_evt && rx_act && run) begin
        rx_sh <= rx_next;
        if (cnt[BIT_W-1:0] == BIT_LAST) begin
          rx_valid_o <= 1'b1;
          rx_data_o  <= rx_next;
          rx_ch_o    <= rx_cur;
        end
      end
    end
  end

  // R2: transmit data moves only after a detected rising edge
  a_r2_txd_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd_o) |-> $past(rise_evt));
  // R7: the line enable also moves only at rising edges
  a_r7_oe_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd_oe_o) |-> $past(rise_evt));
  // R3: receive strobe follows a falling edge and lasts one cycle
  a_r3_rx_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> $past(fall_evt));
  a_r3_rx_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);
  // R9: at most one channel is handed a slot at a time
  a_r9_ready_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_ready_o));
  // R6: a loaded slot belongs to a transmit-enabled channel
  a_r6_load_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (|tx_ready_o) |-> |(tx_ready_o & tx_en));
endmodule

// File: tb/pcm_tdm_port_tb.sv
module pcm_tdm_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [1:0]  ctl_sel = '0;
  logic [1:0]  ctl_ch = '0;
  logic [6:0]  ctl_data = '0;
  logic        bclk = 1'b0, fsync = 1'b0, rxd = 1'b0;
  logic        txd_o, txd_oe_o, slot_ind_n_o;
  logic [31:0] tx_data = '0;
  logic [3:0]  tx_valid = '0;
  logic [3:0]  tx_ready_o;
  logic [7:0]  rx_data_o;
  logic [1:0]  rx_ch_o;
  logic        rx_valid_o;

  always #4 clk = ~clk;  // 125 MHz

  pcm_tdm_port u_dut (
    .clk, .rst_n,
    .ctl_we_i(ctl_we), .ctl_sel_i(ctl_sel), .ctl_ch_i(ctl_ch), .ctl_data_i(ctl_data),
    .bclk_i(bclk), .fsync_i(fsync), .rxd_i(rxd),
    .txd_o, .txd_oe_o, .slot_ind_n_o,
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o,
    .rx_data_o, .rx_ch_o, .rx_valid_o
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // Bench-side configuration and bus model
  int tx_slot[4], rx_slot[4], pwr[4];
  bit cfg_delay = 1;
  int pos = 0, seed = 0;
  bit run_m = 0, arm_m = 0, fpr = 0, fpf = 0, ovf_m = 0;
  int exp_q[$];
  int exp_hs = 0, exp_rdy = 0, hs_seen = 0, rdy_seen = 0;
  string tag = "";

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int tx_win(input int slot);
    for (int c = 0; c < 4; c++) if (pwr[c][1] && tx_slot[c] == slot) return c;
    return -1;
  endfunction

  function automatic int rx_win(input int slot);
    for (int c = 0; c < 4; c++) if (pwr[c][0] && rx_slot[c] == slot) return c;
    return -1;
  endfunction

  function automatic logic [7:0] rx_pat(input int slot);
    return 8'(seed * 53 + slot * 37 + 11);
  endfunction

  // R11: control write encoding
  task automatic wr(input logic [1:0] sel, input int ch, input int data);
    @(negedge clk);
    ctl_we = 1'b1; ctl_sel = sel; ctl_ch = ch[1:0]; ctl_data = data[6:0];
    case (sel)
      2'b00: tx_slot[ch] = data & 127;
      2'b01: rx_slot[ch] = data & 127;
      2'b10: pwr[ch] = data & 3;
      default: cfg_delay = data[0];
    endcase
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  // Driver: one bit clock period, model predicts and queues results
  task automatic one_bit(input bit fsv);
    int slot, b, tw;
    int rw;
    bit start;
    logic [7:0] tb, rb;
    string align;
    @(negedge clk);
    start = cfg_delay ? arm_m : (fsv && !fpr);
    fpr = fsv; arm_m = 0;
    if (start) begin pos = 0; run_m = 1; ovf_m = 0; end
    else if (run_m) begin
      if (pos == 1023) begin run_m = 0; ovf_m = 1; end
      else pos++;
    end
    tw = -1; rw = -1; b = 0; slot = 0; rb = '0;
    if (run_m) begin
      slot = pos / 8; b = pos % 8;
      tw = tx_win(slot); rw = rx_win(slot); rb = rx_pat(slot);
      if (b == 0 && tw >= 0) begin exp_rdy++; if (tx_valid[tw]) exp_hs++; end
      if (b == 7 && rw >= 0) exp_q.push_back(rw * 256 + int'(rb));
    end
    bclk = 1'b1; fsync = fsv; rxd = run_m ? rb[7-b] : 1'b0;
    repeat (3) @(negedge clk);
    align = cfg_delay ? "R4" : "R5";
    chk(txd_oe_o == (tw >= 0) && slot_ind_n_o == (tw < 0),
        {ovf_m ? "R10" : "R7", " ", align, tag}, "oe/ind", {txd_oe_o, slot_ind_n_o}, {tw >= 0, tw < 0});
    if (tw >= 0) begin
      tb = tx_valid[tw] ? tx_data[tw*8 +: 8] : 8'hFF;
      chk(txd_o == tb[7-b], {"R2 ", align, tag}, "txd bit", txd_o, tb[7-b]);
    end
    @(negedge clk);
    bclk = 1'b0;
    if (fsv && !fpf) arm_m = 1;
    fpf = fsv;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_frames(input int nslots, input int nframes);
    for (int f = 0; f < nframes; f++) begin
      seed++;
      for (int k = 0; k < nslots * 8; k++) one_bit(k == 0);
    end
  endtask

  task automatic end_scn(input int flush);
    for (int k = 0; k < flush; k++) one_bit(1'b0);
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, {"R3", tag}, "rx bytes still owed", exp_q.size(), 0);
    chk(hs_seen == exp_hs, {"R9", tag}, "valid handshakes", hs_seen, exp_hs);
    chk(rdy_seen == exp_rdy, {"R9", tag}, "ready pulses", rdy_seen, exp_rdy);
    exp_q.delete();
    hs_seen = 0; rdy_seen = 0; exp_hs = 0; exp_rdy = 0;
  endtask

  // Monitor: pops expected receive bytes, counts handshakes
  always @(negedge clk) begin
    int e;
    if (rst_n) begin
      if (rx_valid_o) begin
        checks++;
        if (exp_q.size() == 0) begin
          failures++;
          $display("FAIL R3%s unexpected rx actual=%0h expected=none", tag, {rx_ch_o, rx_data_o});
        end else begin
          e = exp_q.pop_front();
          if (int'({rx_ch_o, rx_data_o}) != e) begin
            failures++;
            $display("FAIL R3%s rx ch/byte actual=%0h expected=%0h", tag, {rx_ch_o, rx_data_o}, e);
          end
        end
      end
      rdy_seen += $countones(tx_ready_o);
      hs_seen  += $countones(tx_ready_o & tx_valid);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) begin tx_slot[c] = 0; rx_slot[c] = 0; pwr[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset state at the ports
    chk(txd_oe_o == 1'b0, "R1", "txd_oe_o", txd_oe_o, 0);
    chk(slot_ind_n_o == 1'b1, "R1", "slot_ind_n_o", slot_ind_n_o, 1);
    chk(rx_valid_o == 1'b0 && tx_ready_o == '0, "R1", "strobes", {rx_valid_o, tx_ready_o}, 0);

    // R1 R6: all channels down after reset, nothing driven or captured
    tag = " [R6 idle]";
    tx_data = 32'h1234_5678; tx_valid = 4'hF;
    run_frames(8, 1); end_scn(2);

    // R1: slot numbers default to 0, power ch0 up both ways
    tag = " [R1 slot0]";
    wr(2'b10, 0, 3);
    tx_data = 32'h0000_00C3; tx_valid = 4'h1;
    run_frames(8, 2); end_scn(2);

    // R11 R6 R9: distinct slots, mixed codes, ch1 starved
    tag = " [R11]";
    wr(2'b00, 0, 3);  wr(2'b01, 0, 5);  wr(2'b10, 0, 3);
    wr(2'b00, 1, 1);  wr(2'b01, 1, 1);  wr(2'b10, 1, 3);
    wr(2'b00, 2, 7);  wr(2'b01, 2, 9);  wr(2'b10, 2, 2);
    wr(2'b00, 3, 12); wr(2'b01, 3, 2);  wr(2'b10, 3, 1);
    tx_data = 32'h9E_5A_00_A7; tx_valid = 4'b1101;
    run_frames(32, 2); end_scn(2);

    // R5: same traffic in non-delay alignment
    tag = " [R5]";
    wr(2'b11, 0, 0);
    tx_data = 32'h3C_81_66_4B; tx_valid = 4'hF;
    run_frames(32, 2); end_scn(2);

    // R8: collisions in both directions
    tag = " [R8]";
    wr(2'b11, 0, 1);
    wr(2'b00, 1, 4); wr(2'b00, 2, 4); wr(2'b10, 2, 3); wr(2'b10, 1, 3);
    wr(2'b01, 0, 6); wr(2'b01, 3, 6); wr(2'b10, 3, 3);
    tx_data = 32'h11_22_33_44; tx_valid = 4'hF;
    run_frames(16, 2); end_scn(2);

    // R10: full 128-slot frame, then no wrap without a new frame sync
    tag = " [R10]";
    wr(2'b00, 0, 0);   wr(2'b01, 0, 0);
    wr(2'b00, 3, 127); wr(2'b01, 3, 127);
    wr(2'b10, 1, 0);   wr(2'b10, 2, 0);
    tx_data = 32'hE1_00_00_5D; tx_valid = 4'b1001;
    run_frames(128, 1); end_scn(24);

    // R6: power everything down again
    tag = " [R6 down]";
    for (int c = 0; c < 4; c++) wr(2'b10, c, 0);
    run_frames(32, 1); end_scn(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule